// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the control register file of a stereo audio codec. A controller writes and reads 16-bit words through a word-aligned register address. There is one write port and one read port, and each has its own address and strobe. The file holds the mute and attenuation settings of the mixer, the record source and gain, the general-purpose mode bits, the power-down controls, the extended-feature enables, the two converter sample rates and the channel-status word for the digital output. Every register has its own reset default.

Several access rules are enforced. Odd and unimplemented addresses read as zero. A write to address 00h returns every register to its default, and a read of 00h returns a fixed identity word. Volume fields that overflow saturate. A written sample rate snaps to the closest supported rate. Ready flags read back gated by their power-down controls. The channel-status word is locked while the digital output is enabled. Decoded fields are driven out to the datapath. The effective converter rates fall back to 48000 Hz when variable-rate operation is off.

Top module: `codec_regfile`

## Requirements
- R1: A read of an odd address or of an address that holds no register returns 0000h, and `rd_data` is 0000h whenever `rd_en` is low.
- R2: A read of address 00h returns the identity word 6A90h.
- R3: A write of any data to address 00h returns every register to its default on the next clock edge. A read in the same cycle still returns the previous contents.
- R4: In the master (02h), headphone (04h) and mono (06h) volume registers, a write that sets bit 5 of a 6-bit field stores 11111 in that 5-bit field. The left field is bits 13:8 with overflow bit 13, and the right field is bits 5:0 with overflow bit 5.
- R5: Defaults: 02h/04h/06h = 8000h; 0Ch/0Eh = 8008h; 10h/12h/14h/16h/18h = 8808h; 1Ah = 0000h; 1Ch = 8000h; 20h = 0000h; 26h = 0000h with the ready flags gated; 2Ah = 0030h; 2Ch/32h = BB80h; 3Ah = 2000h.
- R6: Reserved bits read 0. Writable masks: 1Ah = 0707h, 20h = 2380h, 0Eh = 805Fh, 1Ch = 8F0Fh.
- R7: Register 26h keeps bits 15:8 as controls. Bits 3:0 (3 VREF, 2 mixer, 1 DAC, 0 ADC) read `ready_in[i]` AND NOT control bit 8+i. Writes never change bits 7:0.
- R8: A write to 2Ch or 32h stores the nearest of 8000, 11025, 12000, 16000, 22050, 24000, 32000, 44100 and 48000 by absolute difference. A tie goes to the lower rate.
- R9: While bit 0 of 2Ah (variable-rate enable) is 0, `dac_rate` and `adc_rate` are BB80h. Otherwise they follow 2Ch and 32h.
- R10: A write to 3Ah is ignored while bit 2 of 2Ah (digital output enable) is 1. Otherwise 3Ah stores the data masked by BFFEh.
- R11: `master_mute`, `master_att_l` and `master_att_r` follow 02h bits 15, 12:8 and 4:0. `rec_src_l` and `rec_src_r` follow 1Ah bits 10:8 and 2:0. `pd_ctrl` follows 26h bits 15:8. `var_rate_en` and `spdif_en` follow 2Ah bits 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_addr | input | 7 | Write byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read byte address |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| ready_in | input | 4 | Subsystem ready inputs (VREF, mixer, DAC, ADC) |
| master_mute | output | 1 | Master mute |
| master_att_l | output | 5 | Master left attenuation |
| master_att_r | output | 5 | Master right attenuation |
| rec_src_l | output | 3 | Left record source |
| rec_src_r | output | 3 | Right record source |
| pd_ctrl | output | 8 | Power-down controls |
| var_rate_en | output | 1 | Variable-rate enable |
| spdif_en | output | 1 | Digital output enable |
| dac_rate | output | 16 | Effective playback rate |
| adc_rate | output | 16 | Effective record rate |

## Verification
The assertions check several rules on every cycle: zero reads of odd addresses, the identity word, the restore after a reset write, saturation of the master right field, the gating of ready flags by their controls, the lock on the channel-status word, the fixed fallback rate, and that both rate registers always hold a supported rate. Only the bench scenarios can show that a particular rate maps to the right neighbour, including the tie points. The same holds for the exact reserved-bit masks, all the defaults, and the read that still shows the old value while the reset write completes.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;

  localparam int DW       = 16;
  localparam int NSLOT    = 18;
  localparam int NRATES   = 9;
  localparam int PWR_SLOT = 13;
  localparam int EXT_SLOT = 14;
  localparam int DAC_SLOT = 15;
  localparam int ADC_SLOT = 16;
  localparam int CS_SLOT  = 17;
  localparam logic [DW-1:0] ID_WORD   = 16'h6A90;
  localparam logic [DW-1:0] RATE_FULL = 16'hBB80;

  typedef enum logic [2:0] {K_PLAIN, K_SAT, K_RATE, K_GUARD, K_PWR} slot_kind_e;

  function automatic logic [7:0] slot_addr(input int i);
    case (i)
      0: return 8'h02;  1: return 8'h04;  2: return 8'h06;  3: return 8'h0C;
      4: return 8'h0E;  5: return 8'h10;  6: return 8'h12;  7: return 8'h14;
      8: return 8'h16;  9: return 8'h18; 10: return 8'h1A; 11: return 8'h1C;
      12: return 8'h20; 13: return 8'h26; 14: return 8'h2A; 15: return 8'h2C;
      16: return 8'h32; default: return 8'h3A;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_default(input int i);
    case (i)
      0, 1, 2, 11:       return 16'h8000;
      3, 4:              return 16'h8008;
      5, 6, 7, 8, 9:     return 16'h8808;
      14:                return 16'h0030;
      15, 16:            return RATE_FULL;
      17:                return 16'h2000;
      default:           return 16'h0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_mask(input int i);
    case (i)
      0, 1, 5, 6, 7, 8, 9: return 16'h9F1F;
      2, 3:              return 16'h801F;
      4:                 return 16'h805F;
      10:                return 16'h0707;
      11:                return 16'h8F0F;
      12:                return 16'h2380;
      13:                return 16'hFF00;
      14:                return 16'h0035;
      15, 16:            return 16'hFFFF;
      default:           return 16'hBFFE;
    endcase
  endfunction

  function automatic slot_kind_e slot_kind(input int i);
    case (i)
      0, 1, 2: return K_SAT;
      13:      return K_PWR;
      15, 16:  return K_RATE;
      17:      return K_GUARD;
      default: return K_PLAIN;
    endcase
  endfunction

  // Overflow bit of each 6-bit field forces the 5-bit field to all ones.
  function automatic logic [DW-1:0] sat_fields(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    if (v[13]) r[12:8] = 5'h1F;
    if (v[5])  r[4:0]  = 5'h1F;
    return r;
  endfunction

  function automatic logic [DW-1:0] rate_at(input int k);
    case (k)
      0: return 16'd8000;  1: return 16'd11025; 2: return 16'd12000;
      3: return 16'd16000; 4: return 16'd22050; 5: return 16'd24000;
      6: return 16'd32000; 7: return 16'd44100; default: return 16'd48000;
    endcase
  endfunction

  function automatic logic [DW:0] abs_diff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? ({1'b0, a} - {1'b0, b}) : ({1'b0, b} - {1'b0, a});
  endfunction

  // Ascending scan with strict comparison keeps the lower rate on a tie.
  function automatic logic [DW-1:0] snap_rate(input logic [DW-1:0] v);
    logic [DW-1:0] best;
    logic [DW:0]   best_d;
    logic [DW:0]   d;
    best   = rate_at(0);
    best_d = abs_diff(v, best);
    for (int k = 1; k < NRATES; k++) begin
      d = abs_diff(v, rate_at(k));
      if (d < best_d) begin
        best   = rate_at(k);
        best_d = d;
      end
    end
    return best;
  endfunction

  function automatic logic is_rate(input logic [DW-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NRATES; k++) if (v == rate_at(k)) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/cr_addr_decode.sv
module cr_addr_decode
  import codec_regfile_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NREG   = NSLOT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output logic              id_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [7:0] A = slot_addr(i);
    assign hit[i] = (addr == A[ADDR_W-1:0]);
  end
  assign id_hit = (addr == '0);

  always_comb begin
    p_single_slot_r1: assert ($onehot0({hit, id_hit}));
  end
endmodule

// File: rtl/cr_rate_snap.sv
module cr_rate_snap
  import codec_regfile_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] snapped
);
  always_comb snapped = snap_rate(raw);
endmodule

// File: rtl/cr_pwr_status.sv
module cr_pwr_status #(
  parameter int NRDY = 4
) (
  input  logic [NRDY-1:0] ready_in,
  input  logic [NRDY-1:0] pd_bits,
  output logic [NRDY-1:0] status
);
  assign status = ready_in & ~pd_bits;
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regfile_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NRDY   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic [NRDY-1:0]   ready_in,
  output logic              master_mute,
  output logic [4:0]        master_att_l,
  output logic [4:0]        master_att_r,
  output logic [2:0]        rec_src_l,
  output logic [2:0]        rec_src_r,
  output logic [7:0]        pd_ctrl,
  output logic              var_rate_en,
  output logic              spdif_en,
  output logic [DW-1:0]     dac_rate,
  output logic [DW-1:0]     adc_rate
);
  localparam int NREG = NSLOT;

  logic [NREG-1:0]          wr_hit, rd_hit;
  logic                     wr_id_hit, rd_id_hit;
  logic                     reset_all;
  logic [DW-1:0]            rate_snapped;
  logic [NRDY-1:0]          ready_view;
  logic [NREG-1:0][DW-1:0]  regv;

  cr_addr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_wdec (
    .addr(wr_addr), .hit(wr_hit), .id_hit(wr_id_hit));
  cr_addr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_rdec (
    .addr(rd_addr), .hit(rd_hit), .id_hit(rd_id_hit));
  cr_rate_snap #(.W(DW)) u_snap (.raw(wr_data), .snapped(rate_snapped));
  cr_pwr_status #(.NRDY(NRDY)) u_pwr (
    .ready_in(ready_in), .pd_bits(regv[PWR_SLOT][8 +: NRDY]), .status(ready_view));

  assign reset_all = wr_en && wr_id_hit;
  assign spdif_en  = regv[EXT_SLOT][2];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] DEF  = slot_default(i);
    localparam logic [DW-1:0] MASK = slot_mask(i);
    localparam slot_kind_e    KIND = slot_kind(i);
    logic          we;
    logic [DW-1:0] nxt;
    logic [DW-1:0] q;

    if (KIND == K_GUARD) begin : g_guard
      assign we = wr_en && wr_hit[i] && !spdif_en;
    end else begin : g_open
      assign we = wr_en && wr_hit[i];
    end

    if (KIND == K_SAT) begin : g_sat
      assign nxt = sat_fields(wr_data) & MASK;
    end else if (KIND == K_RATE) begin : g_rate
      assign nxt = rate_snapped & MASK;
    end else begin : g_plain
      assign nxt = wr_data & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= DEF;
      else if (reset_all) q <= DEF;
      else if (we)        q <= nxt;
    end
    assign regv[i] = q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (rd_id_hit) rd_data = ID_WORD;
      for (int i = 0; i < NREG; i++) begin
        if (rd_hit[i]) begin
          if (i == PWR_SLOT)
            rd_data = rd_data | {regv[i][15:8], {(8-NRDY){1'b0}}, ready_view};
          else
            rd_data = rd_data | regv[i];
        end
      end
    end
  end

  assign master_mute  = regv[0][15];
  assign master_att_l = regv[0][12:8];
  assign master_att_r = regv[0][4:0];
  assign rec_src_l    = regv[10][10:8];
  assign rec_src_r    = regv[10][2:0];
  assign pd_ctrl      = regv[PWR_SLOT][15:8];
  assign var_rate_en  = regv[EXT_SLOT][0];
  assign dac_rate     = var_rate_en ? regv[DAC_SLOT] : RATE_FULL;
  assign adc_rate     = var_rate_en ? regv[ADC_SLOT] : RATE_FULL;

  p_odd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[0]) |-> (rd_data == '0));
  p_id_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == '0) |-> (rd_data == ID_WORD));
  p_reset_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> (master_mute && master_att_l == '0 &&
                                  pd_ctrl == '0 && !var_rate_en));
  p_sat_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 7'h02 && wr_data[5]) |=> (master_att_r == 5'h1F));
  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 7'h26 && pd_ctrl[0]) |-> !rd_data[0]);
  p_rate_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_rate(regv[DAC_SLOT]) && is_rate(regv[ADC_SLOT]));
  p_fixed_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !var_rate_en |-> (dac_rate == RATE_FULL && adc_rate == RATE_FULL));
  p_cs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 7'h3A && spdif_en) |=> $stable(regv[CS_SLOT]));
endmodule

// File: tb/tb_codec_regfile.sv
module tb_codec_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  wr_addr = '0, rd_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  ready_in = 4'hF;
  logic        master_mute, var_rate_en, spdif_en;
  logic [4:0]  master_att_l, master_att_r;
  logic [2:0]  rec_src_l, rec_src_r;
  logic [7:0]  pd_ctrl;
  logic [15:0] dac_rate, adc_rate;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  codec_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .ready_in(ready_in),
    .master_mute(master_mute), .master_att_l(master_att_l), .master_att_r(master_att_r),
    .rec_src_l(rec_src_l), .rec_src_r(rec_src_r), .pd_ctrl(pd_ctrl),
    .var_rate_en(var_rate_en), .spdif_en(spdif_en), .dac_rate(dac_rate), .adc_rate(adc_rate));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
    @(negedge clk); rd_addr = a; rd_en = 1'b1;
    #2 chk(req, rd_data, exp);
    rd_en = 1'b0;
  endtask

  // Nearest rate by midpoint thresholds; midpoint ties go low.
  function automatic logic [15:0] exp_rate(input int v);
    if (v <= 9512)  return 16'd8000;
    if (v <= 11512) return 16'd11025;
    if (v <= 14000) return 16'd12000;
    if (v <= 19025) return 16'd16000;
    if (v <= 23025) return 16'd22050;
    if (v <= 28000) return 16'd24000;
    if (v <= 38050) return 16'd32000;
    if (v <= 46050) return 16'd44100;
    return 16'd48000;
  endfunction

  task automatic t_defaults;
    @(negedge clk); rd_addr = 7'h02; rd_en = 1'b0; #2 chk("R1 idle read", rd_data, 16'h0000);
    rd_chk("R5 master", 7'h02, 16'h8000);
    rd_chk("R5 phone", 7'h0C, 16'h8008);
    rd_chk("R5 line", 7'h10, 16'h8808);
    rd_chk("R5 pcm", 7'h18, 16'h8808);
    rd_chk("R5 recgain", 7'h1C, 16'h8000);
    rd_chk("R5 ext", 7'h2A, 16'h0030);
    rd_chk("R5 dac rate", 7'h2C, 16'hBB80);
    rd_chk("R5 cs", 7'h3A, 16'h2000);
    rd_chk("R5 pwr", 7'h26, 16'h000F);
  endtask

  task automatic t_zero_reads;
    rd_chk("R1 odd", 7'h03, 16'h0000);
    rd_chk("R1 odd 0D", 7'h0D, 16'h0000);
    rd_chk("R1 unimpl", 7'h24, 16'h0000);
    rd_chk("R2 id", 7'h00, 16'h6A90);
    wr(7'h05, 16'h1234);
    rd_chk("R1 odd write ignored", 7'h04, 16'h8000);
  endtask

  task automatic t_sat;
    wr(7'h02, 16'h2025); rd_chk("R4 master both", 7'h02, 16'h1F1F);
    wr(7'h02, 16'h0A05); rd_chk("R4 master no sat", 7'h02, 16'h0A05);
    wr(7'h06, 16'h0030); rd_chk("R4 mono", 7'h06, 16'h001F);
    wr(7'h04, 16'hA011); rd_chk("R4 headphone left", 7'h04, 16'h9F11);
  endtask

  task automatic t_masks;
    wr(7'h1A, 16'hFFFF); rd_chk("R6 recsel", 7'h1A, 16'h0707);
    wr(7'h20, 16'hFFFF); rd_chk("R6 general", 7'h20, 16'h2380);
    wr(7'h0E, 16'hFFFF); rd_chk("R6 mic", 7'h0E, 16'h805F);
    wr(7'h1C, 16'hFFFF); rd_chk("R6 recgain", 7'h1C, 16'h8F0F);
  endtask

  task automatic t_pwr;
    ready_in = 4'hF;
    wr(7'h26, 16'h00FF); rd_chk("R7 low ignored", 7'h26, 16'h000F);
    wr(7'h26, 16'h0500); rd_chk("R7 gated", 7'h26, 16'h050A);
    ready_in = 4'h6;    rd_chk("R7 follows input", 7'h26, 16'h0502);
    wr(7'h26, 16'hFF00); rd_chk("R7 all gated", 7'h26, 16'hFF00);
    chk("R11 pd_ctrl", {8'h0, pd_ctrl}, 16'h00FF);
    wr(7'h26, 16'h0000); ready_in = 4'hF;
  endtask

  task automatic t_rates;
    int vals[6] = '{14000, 14001, 0, 65535, 19025, 9513};
    foreach (vals[k]) begin
      wr(7'h2C, 16'(vals[k]));
      rd_chk("R8 snap", 7'h2C, exp_rate(vals[k]));
    end
    wr(7'h32, 16'd44100); rd_chk("R8 exact adc", 7'h32, 16'hAC44);
  endtask

  task automatic t_vra;
    wr(7'h2C, 16'd12000);
    @(negedge clk); chk("R9 fixed dac", dac_rate, 16'hBB80); chk("R9 fixed adc", adc_rate, 16'hBB80);
    wr(7'h2A, 16'h0031);
    @(negedge clk); chk("R9 var dac", dac_rate, 16'h2EE0); chk("R9 var adc", adc_rate, 16'hAC44);
    chk("R11 var_rate_en", {15'h0, var_rate_en}, 16'h0001);
  endtask

  task automatic t_guard;
    wr(7'h2A, 16'h0034);
    @(negedge clk); chk("R11 spdif_en", {15'h0, spdif_en}, 16'h0001);
    wr(7'h3A, 16'hFFFF); rd_chk("R10 locked", 7'h3A, 16'h2000);
    wr(7'h2A, 16'h0030);
    wr(7'h3A, 16'hFFFF); rd_chk("R10 open", 7'h3A, 16'hBFFE);
  endtask

  task automatic t_outputs;
    wr(7'h02, 16'h8A15);
    @(negedge clk);
    chk("R11 mute", {15'h0, master_mute}, 16'h0001);
    chk("R11 att_l", {11'h0, master_att_l}, 16'h000A);
    chk("R11 att_r", {11'h0, master_att_r}, 16'h0015);
    wr(7'h1A, 16'h0305);
    @(negedge clk);
    chk("R11 rec_src", {5'h0, rec_src_l, 5'h0, rec_src_r}, 16'h0305);
  endtask

  task automatic t_regreset;
    @(negedge clk);
    wr_addr = 7'h00; wr_data = 16'h5555; wr_en = 1'b1;
    rd_addr = 7'h02; rd_en = 1'b1;
    #2 chk("R3 old value same cycle", rd_data, 16'h8A15);
    @(negedge clk); wr_en = 1'b0;
    #2 chk("R3 master restored", rd_data, 16'h8000);
    rd_en = 1'b0;
    rd_chk("R3 recsel restored", 7'h1A, 16'h0000);
    rd_chk("R3 rate restored", 7'h2C, 16'hBB80);
    rd_chk("R3 cs restored", 7'h3A, 16'h2000);
    rd_chk("R3 ext restored", 7'h2A, 16'h0030);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_defaults();
    t_zero_reads();
    t_sat();
    t_masks();
    t_pwr();
    t_rates();
    t_vra();
    t_guard();
    t_outputs();
    t_regreset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule